// File: doc/BRIEF.md
# Pad Ownership Multiplexer

This block decides, for each of `NPINS` I/O pads, which of three sources drives the pad: peripheral A, peripheral B, or the general purpose port. Each peripheral presents an enable, a data bit, an output-enable bit and a control-mode bit for every pad. The mode bit says whether the peripheral takes the whole driver or lets the port's direction bit and latch set the driver. When both peripherals are enabled, A wins. The port drives only when neither peripheral is enabled.

The pad level goes back to both peripherals and to the port read path at all times. When the pad is driven, the level seen inside is the driven value. Software can therefore inject events into an input-type peripheral by turning its pad into an output and writing the latch. A subset of pads, chosen by a parameter mask, is shared with an analog converter. Such a pad works digitally only while its configuration bit is 1. The block has no state: every output is a combinational function of the current inputs.

Top module: `pad_owner_mux`

## Requirements
- R1: When `pa_en` is 1 for a pad, peripheral A owns that pad, whatever `pb_en` is.
- R2: When `pb_en` is 1 and `pa_en` is 0, peripheral B owns the pad. Exactly one source owns each pad at any time.
- R3: When both enables are 0, the port owns the pad. Then `pad_out` = `gpio_lat` and `pad_oe` = NOT `gpio_tris` (direction bit 1 = input, 0 = output).
- R4: Mode bit 1 means full peripheral control. When the owning peripheral has mode bit 1, `pad_out` and `pad_oe` equal that peripheral's data and output-enable bits, and the latch and direction bits have no effect.
- R5: Mode bit 0 means direction is left to the port. When the owning peripheral has mode bit 0, `pad_oe` = NOT `gpio_tris` and `pad_out` = `gpio_lat`, and that peripheral's data and output-enable bits have no effect.
- R6: The digital input level is `pad_out` when `pad_oe` is 1, and `pad_in` otherwise. This lets a latch write reach a peripheral input.
- R7: `pa_in`, `pb_in` and `gpio_rd` all carry the digital input level for every owner. The pad stays readable while a peripheral owns it.
- R8: On a pad whose bit in `ANA_SHARED` is 1 and whose `ana_dig` bit is 0, `pad_oe` and `pad_out` are 0, and all three input views read 0. On pads outside the mask, `ana_dig` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pa_en | input | NPINS | Peripheral A enable per pad |
| pa_do | input | NPINS | Peripheral A output data |
| pa_oe | input | NPINS | Peripheral A output enable |
| pa_mode | input | NPINS | Peripheral A control mode (1 full, 0 direction from port) |
| pb_en | input | NPINS | Peripheral B enable per pad |
| pb_do | input | NPINS | Peripheral B output data |
| pb_oe | input | NPINS | Peripheral B output enable |
| pb_mode | input | NPINS | Peripheral B control mode (1 full, 0 direction from port) |
| gpio_lat | input | NPINS | Port output latch |
| gpio_tris | input | NPINS | Port direction (1 input, 0 output) |
| ana_dig | input | NPINS | Digital-use bit for analog-shared pads (1 digital) |
| pad_in | input | NPINS | Level seen at the pad receiver |
| pad_out | output | NPINS | Data to the pad driver |
| pad_oe | output | NPINS | Pad driver enable |
| pa_in | output | NPINS | Input level to peripheral A |
| pb_in | output | NPINS | Input level to peripheral B |
| gpio_rd | output | NPINS | Port read value |

## Verification
Two functions can apply to the same pad in the same evaluation. The first is priority arbitration between the two enabled peripherals. The second is the analog gate, which overrides whichever owner has won. The driven-value loopback also overlaps with the user-settable direction path. The bench drives every combination of the twelve per-pad control and data bits on every pad, using a different permutation on each pad. So both enables, both modes, the direction bit and the analog bit are all active together in many vectors. A behavioural model decides the expected winner, driver state and input level for each vector. Every output of every pad is then compared with that model, and each check is tagged with the requirement that decided its value.

// File: rtl/pom_pkg.sv
package pom_pkg;

  typedef enum logic [1:0] {
    OWN_GPIO = 2'd0,
    OWN_PA   = 2'd1,
    OWN_PB   = 2'd2
  } owner_e;

  localparam logic CTL_USER   = 1'b0;
  localparam logic CTL_MODULE = 1'b1;

  // Fixed priority: A, then B, then port.
  function automatic owner_e pick_owner(input logic a_en, input logic b_en);
    if (a_en)      return OWN_PA;
    else if (b_en) return OWN_PB;
    else           return OWN_GPIO;
  endfunction

  // A pad outside the analog mask is always digital.
  function automatic logic digital_ok(input logic shared, input logic cfg);
    return !shared || cfg;
  endfunction

  // Level seen inside: driven value when driving, else pad receiver.
  function automatic logic seen_level(input logic oe, input logic drv, input logic pin);
    return oe ? drv : pin;
  endfunction

endpackage

// File: rtl/pom_arbiter.sv
module pom_arbiter
  import pom_pkg::*;
(
  input  logic   a_en,
  input  logic   b_en,
  output owner_e owner,
  output logic   own_a,
  output logic   own_b,
  output logic   own_g
);
  always_comb begin
    owner = pick_owner(a_en, b_en);
    own_a = (owner == OWN_PA);
    own_b = (owner == OWN_PB);
    own_g = (owner == OWN_GPIO);
  end
endmodule

// File: rtl/pom_drive.sv
module pom_drive
  import pom_pkg::*;
(
  input  owner_e owner,
  input  logic   a_do,
  input  logic   a_oe,
  input  logic   a_mode,
  input  logic   b_do,
  input  logic   b_oe,
  input  logic   b_mode,
  input  logic   lat,
  input  logic   tris,
  input  logic   dig,
  output logic   drv_out,
  output logic   drv_oe
);
  logic sel_do, sel_oe, sel_mode, by_port;

  always_comb begin
    case (owner)
      OWN_PA:  begin sel_do = a_do; sel_oe = a_oe; sel_mode = a_mode; end
      OWN_PB:  begin sel_do = b_do; sel_oe = b_oe; sel_mode = b_mode; end
      default: begin sel_do = 1'b0; sel_oe = 1'b0; sel_mode = CTL_USER; end
    endcase
    by_port = (owner == OWN_GPIO) || (sel_mode == CTL_USER);
    if (!dig) begin
      drv_out = 1'b0;
      drv_oe  = 1'b0;
    end else if (by_port) begin
      drv_out = lat;
      drv_oe  = !tris;
    end else begin
      drv_out = sel_do;
      drv_oe  = sel_oe;
    end
  end
endmodule

// File: rtl/pom_input.sv
module pom_input
  import pom_pkg::*;
(
  input  logic pin,
  input  logic drv_out,
  input  logic drv_oe,
  input  logic dig,
  output logic din
);
  always_comb din = dig && seen_level(drv_oe, drv_out, pin);
endmodule

// File: rtl/pom_lane.sv
module pom_lane
  import pom_pkg::*;
#(
  parameter bit SHARED = 1'b0
) (
  input  logic a_en, a_do, a_oe, a_mode,
  input  logic b_en, b_do, b_oe, b_mode,
  input  logic lat,
  input  logic tris,
  input  logic cfg,
  input  logic pin,
  output logic drv_out,
  output logic drv_oe,
  output logic din,
  output logic own_a,
  output logic own_b,
  output logic own_g
);
  owner_e owner;
  logic   dig;

  always_comb dig = digital_ok(SHARED, cfg);

  pom_arbiter u_arb (
    .a_en (a_en), .b_en (b_en), .owner (owner),
    .own_a(own_a), .own_b(own_b), .own_g(own_g)
  );

  pom_drive u_drv (
    .owner (owner),
    .a_do  (a_do), .a_oe (a_oe), .a_mode (a_mode),
    .b_do  (b_do), .b_oe (b_oe), .b_mode (b_mode),
    .lat   (lat),  .tris (tris), .dig    (dig),
    .drv_out(drv_out), .drv_oe(drv_oe)
  );

  pom_input u_in (
    .pin(pin), .drv_out(drv_out), .drv_oe(drv_oe), .dig(dig), .din(din)
  );
endmodule

// File: rtl/pad_owner_mux.sv
module pad_owner_mux #(
  parameter int                NPINS      = 8,
  parameter logic [NPINS-1:0]  ANA_SHARED = 8'h0F
) (
  input  logic [NPINS-1:0] pa_en,
  input  logic [NPINS-1:0] pa_do,
  input  logic [NPINS-1:0] pa_oe,
  input  logic [NPINS-1:0] pa_mode,
  input  logic [NPINS-1:0] pb_en,
  input  logic [NPINS-1:0] pb_do,
  input  logic [NPINS-1:0] pb_oe,
  input  logic [NPINS-1:0] pb_mode,
  input  logic [NPINS-1:0] gpio_lat,
  input  logic [NPINS-1:0] gpio_tris,
  input  logic [NPINS-1:0] ana_dig,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pa_in,
  output logic [NPINS-1:0] pb_in,
  output logic [NPINS-1:0] gpio_rd
);
  // Ownership per pad, brought out for the checker.
  logic [NPINS-1:0] own_a, own_b, own_g;
  logic [NPINS-1:0] din;

  for (genvar i = 0; i < NPINS; i++) begin : g_lane
    pom_lane #(.SHARED(ANA_SHARED[i])) u_lane (
      .a_en (pa_en[i]), .a_do (pa_do[i]), .a_oe (pa_oe[i]), .a_mode (pa_mode[i]),
      .b_en (pb_en[i]), .b_do (pb_do[i]), .b_oe (pb_oe[i]), .b_mode (pb_mode[i]),
      .lat  (gpio_lat[i]), .tris (gpio_tris[i]), .cfg (ana_dig[i]), .pin (pad_in[i]),
      .drv_out(pad_out[i]), .drv_oe(pad_oe[i]), .din(din[i]),
      .own_a(own_a[i]), .own_b(own_b[i]), .own_g(own_g[i])
    );
  end

  assign pa_in   = din;
  assign pb_in   = din;
  assign gpio_rd = din;
endmodule

// File: rtl/pad_owner_mux_chk.sv
module pad_owner_mux_chk #(
  parameter int               NPINS      = 8,
  parameter logic [NPINS-1:0] ANA_SHARED = 8'h0F
) (
  input logic [NPINS-1:0] pa_en, pa_do, pa_oe, pa_mode,
  input logic [NPINS-1:0] pb_en, pb_do, pb_oe, pb_mode,
  input logic [NPINS-1:0] gpio_lat, gpio_tris, ana_dig, pad_in,
  input logic [NPINS-1:0] pad_out, pad_oe, pa_in, pb_in, gpio_rd,
  input logic [NPINS-1:0] own_a, own_b, own_g
);
  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      if (!$isunknown({pa_en[i], pa_do[i], pa_oe[i], pa_mode[i], pb_en[i], pb_do[i],
                       pb_oe[i], pb_mode[i], gpio_lat[i], gpio_tris[i], ana_dig[i],
                       pad_in[i], pad_out[i], pad_oe[i], pa_in[i], pb_in[i],
                       gpio_rd[i], own_a[i], own_b[i], own_g[i]})) begin
        AST_A_WINS: assert (!pa_en[i] || own_a[i]); // R1
        AST_ONE_OWNER: assert ($countones({own_a[i], own_b[i], own_g[i]}) == 1); // R2
        AST_PORT_IDLE: assert (!own_g[i] || (!pa_en[i] && !pb_en[i])); // R3
        AST_FULL_CTRL: assert (!(own_b[i] && pb_mode[i] && (!ANA_SHARED[i] || ana_dig[i]))
                               || (pad_oe[i] == pb_oe[i] && pad_out[i] == pb_do[i])); // R4
        AST_USER_DIR: assert (!(own_a[i] && !pa_mode[i] && (!ANA_SHARED[i] || ana_dig[i]))
                              || (pad_oe[i] != gpio_tris[i])); // R5
        AST_LOOPBACK: assert (!pad_oe[i] || (gpio_rd[i] == pad_out[i])); // R6
        AST_SAME_VIEW: assert (pa_in[i] == gpio_rd[i] && pb_in[i] == gpio_rd[i]); // R7
        AST_ANALOG_OFF: assert (!(ANA_SHARED[i] && !ana_dig[i])
                                || (!pad_oe[i] && !pad_out[i] && !gpio_rd[i])); // R8
      end
    end
  end
endmodule

bind pad_owner_mux pad_owner_mux_chk #(.NPINS(NPINS), .ANA_SHARED(ANA_SHARED)) u_chk (
  .pa_en(pa_en), .pa_do(pa_do), .pa_oe(pa_oe), .pa_mode(pa_mode),
  .pb_en(pb_en), .pb_do(pb_do), .pb_oe(pb_oe), .pb_mode(pb_mode),
  .gpio_lat(gpio_lat), .gpio_tris(gpio_tris), .ana_dig(ana_dig), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .pa_in(pa_in), .pb_in(pb_in), .gpio_rd(gpio_rd),
  .own_a(own_a), .own_b(own_b), .own_g(own_g)
);

// File: tb/pad_owner_mux_test.sv
module pad_owner_mux_test;
  localparam int          NP     = 8;
  localparam logic [NP-1:0] SHMASK = 8'h0F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk; // 50 MHz

  logic [NP-1:0] pa_en, pa_do, pa_oe, pa_mode, pb_en, pb_do, pb_oe, pb_mode;
  logic [NP-1:0] gpio_lat, gpio_tris, ana_dig, pad_in;
  logic [NP-1:0] pad_out, pad_oe, pa_in, pb_in, gpio_rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pad_owner_mux #(.NPINS(NP), .ANA_SHARED(SHMASK)) uut (
    .pa_en(pa_en), .pa_do(pa_do), .pa_oe(pa_oe), .pa_mode(pa_mode),
    .pb_en(pb_en), .pb_do(pb_do), .pb_oe(pb_oe), .pb_mode(pb_mode),
    .gpio_lat(gpio_lat), .gpio_tris(gpio_tris), .ana_dig(ana_dig), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pa_in(pa_in), .pb_in(pb_in), .gpio_rd(gpio_rd)
  );

  task automatic chk(string req, int pin, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pad %0d %s: actual=%b expected=%b", req, pin, what, act, exp);
    end
  endtask

  // Apply a 12-bit pattern to one pad.
  task automatic put(int i, logic [11:0] v);
    pa_en[i] = v[0];  pb_en[i] = v[1];  pa_mode[i] = v[2]; pb_mode[i] = v[3];
    gpio_tris[i] = v[4]; gpio_lat[i] = v[5]; pa_do[i] = v[6]; pa_oe[i] = v[7];
    pb_do[i] = v[8];  pb_oe[i] = v[9];  pad_in[i] = v[10]; ana_dig[i] = v[11];
  endtask

  // Behavioural reference for one pad.
  task automatic compare(int i);
    int   src;
    logic full, e_oe, e_out, e_in, usable;
    string rq;
    src = pa_en[i] ? 1 : (pb_en[i] ? 2 : 0);
    full = (src == 1) ? pa_mode[i] : ((src == 2) ? pb_mode[i] : 1'b0);
    usable = !(SHMASK[i] == 1'b1 && ana_dig[i] == 1'b0);
    if (!usable)        begin e_oe = 0; e_out = 0; end
    else if (!full)     begin e_oe = ~gpio_tris[i]; e_out = gpio_lat[i]; end
    else if (src == 1)  begin e_oe = pa_oe[i]; e_out = pa_do[i]; end
    else                begin e_oe = pb_oe[i]; e_out = pb_do[i]; end
    e_in = !usable ? 1'b0 : (e_oe ? e_out : pad_in[i]);
    if (!usable)                 rq = "R8";
    else if (pa_en[i] && pb_en[i]) rq = "R1";
    else if (src == 2)           rq = "R2";
    else if (src == 0)           rq = "R3";
    else if (full)               rq = "R4";
    else                         rq = "R5";
    chk(rq, i, "pad_oe", pad_oe[i], e_oe);
    chk(rq, i, "pad_out", pad_out[i], e_out);
    chk(usable ? "R6" : "R8", i, "pa_in", pa_in[i], e_in);
    chk(usable ? "R7" : "R8", i, "pb_in", pb_in[i], e_in);
    chk(usable ? "R7" : "R8", i, "gpio_rd", gpio_rd[i], e_in);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) put(i, 12'h000);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle state: everything low; port owns, latch 0, analog pads off.
    for (int i = 0; i < NP; i++) compare(i);
    for (int idx = 0; idx < 4096; idx++) begin
      @(posedge clk);
      #1;
      for (int i = 0; i < NP; i++) put(i, 12'(idx) ^ 12'(i * 12'h2B5));
      @(negedge clk);
      for (int i = 0; i < NP; i++) compare(i);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule